// File: doc/BRIEF.md
# Key-Return Standby Wake Controller

This block decides when a sleeping controller leaves standby. It watches seven groups of key-return pins: one input-only group, three open-drain groups (one switched bit by bit, two switched as whole 4-bit units), one bit-switched group that can be push-pull or open-drain, a 3-bit group with a selectable wake level per bit, and a single pin. The single pin can serve either as a key-return line or as an external interrupt input. Each pin's wake condition is evaluated from its group rules, its direction and its configured wake level. While the standby-active input is high, the first cycle in which any pin meets its condition produces a one-cycle wake pulse and records the responsible pins in a sticky source mask.

The block also reports, for every pin, the direction, the pull-up and pull-down enables and the output type (open-drain or push-pull) that the pad logic should apply. These depend on direction, on the resistor-enable and wake-level settings, and on whether key-matrix scanning is in use. Pin inputs pass through a two-flop synchroniser. The interrupt path also passes through a stability filter, so a level is accepted only after it has held for a programmable number of cycles.

Top module: `kr_wake_ctrl`

## Requirements
- R1: A low level on any line of the input-only group (pin index 0..3 in the mask) wakes the device in every configuration.
- R2: The two whole-unit groups (mask bits 8..11 and 12..15) have one direction bit each (1 = output). While set, none of that group's four pins can wake. While clear, any low pin of the group wakes.
- R3: In the bit-switched groups (mask bits 4..7 and 16..19), a pin wakes only while its own direction bit is 0 (input) and the pin is low.
- R4: For the 3-bit group (mask bits 20..22, direction bit 0 = input) and the single pin (mask bit 23, key-return function), the per-bit level setting (1 = high) selects the pin level that wakes.
- R5: Pull selection: an input pin with its resistor enabled gets a pull-up when its wake level is low and a pull-down when it is high. Without the resistor it gets neither. The fixed-pull groups (bits 0..15) have a pull-up while they are inputs. Bits 16..19 have a pull-up as inputs when key-matrix mode is on or their resistor is enabled. No output pin has a pull.
- R6: The direction output equals the pin's output setting. Bits 4..15 are open-drain when outputs. Bits 16..22 are open-drain when outputs in key-matrix mode and push-pull otherwise.
- R7: When the single pin is in interrupt function, its key-return condition is ignored. It wakes the device only when the interrupt-enable flag is set and the filtered level newly changes to the selected level.
- R8: The interrupt filter accepts a new level only after the synchronised pin has differed from the accepted level for FILT_CYC consecutive cycles. A pulse of FILT_CYC-2 cycles is ignored. A held change produces the wake FILT_CYC+3 cycles after the pin changes.
- R9: A key-return pin change reaches the wake output three clock edges later. The wake is a single-cycle pulse and is not repeated while standby stays asserted.
- R10: While the standby input is low, no wake pulse is produced and the source mask is not updated.
- R11: The source mask keeps its bits until the clear input is pulsed. A clear in the same cycle as a wake leaves exactly the new sources.
- R12: After reset the wake output and the source mask are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_i | input | 1 | Standby active; enables wake evaluation |
| km_mode_i | input | 1 | Key-matrix mode selected |
| ka_pin_i | input | KW | Input-only group pins |
| kb_pin_i | input | KW | Bit-switched open-drain group pins |
| kc_pin_i | input | KW | First whole-unit group pins |
| kd_pin_i | input | KW | Second whole-unit group pins |
| ke_pin_i | input | KW | Bit-switched push-pull/open-drain group pins |
| kf_pin_i | input | FW | Level-selectable group pins |
| kg_pin_i | input | 1 | Dual-function single pin |
| kb_dir_i | input | KW | Per-bit direction, 1 = output |
| kc_dir_i | input | 1 | Whole-unit direction, 1 = output |
| kd_dir_i | input | 1 | Whole-unit direction, 1 = output |
| ke_dir_i | input | KW | Per-bit direction, 1 = output |
| kf_dir_i | input | FW | Per-bit direction, 1 = output |
| ke_res_i | input | KW | Per-bit resistor enable |
| kf_res_i | input | FW | Per-bit resistor enable |
| kf_lvl_i | input | FW | Per-bit wake level, 1 = high |
| kg_res_i | input | 1 | Resistor enable for the single pin |
| kg_lvl_i | input | 1 | Wake / interrupt level for the single pin, 1 = high |
| kg_int_sel_i | input | 1 | Single pin in interrupt function |
| int_en_i | input | 1 | Interrupt enable flag |
| src_clr_i | input | 1 | Clear the source mask |
| wake_o | output | 1 | One-cycle wake pulse |
| src_o | output | 5*KW+FW+1 | Sticky wake source mask |
| oe_o | output | 5*KW+FW+1 | Pin is an output |
| pu_o | output | 5*KW+FW+1 | Pull-up enable |
| pd_o | output | 5*KW+FW+1 | Pull-down enable |
| od_o | output | 5*KW+FW+1 | Output stage is open-drain |

## Verification
The bench builds the block with the default group widths (KW = 4, FW = 3) and shortens FILT_CYC to 6. With this value, both the rejected short glitch and the accepted held level on the interrupt path fit into a few dozen cycles, and the exact acceptance cycle can be checked. The 24-pin mask keeps every group kind present, so random configurations cover direction, level, resistor and key-matrix combinations across all pin kinds in one run.

// File: rtl/kr_pkg.sv
`timescale 1ns/1ps
// Shared types for the key-return wake controller.
// Assumes the pin mask is laid out group by group: input-only, bit-switched
// open-drain, two whole-unit groups, bit-switched push-pull, level group, single pin.
package kr_pkg;

    typedef enum logic [2:0] {
        PK_IN_LOW,   // input only, wakes on low, fixed pull-up
        PK_OD_LOW,   // open-drain I/O, wakes on low while input
        PK_SW_LOW,   // push-pull or open-drain I/O, wakes on low while input
        PK_SW_LVL,   // push-pull or open-drain I/O, selectable wake level
        PK_IN_LVL    // input only, selectable wake level
    } pin_kind_e;

    // Map a pin index of the flat mask to its kind.
    function automatic pin_kind_e kind_of(input int idx, input int kw, input int fw);
        if (idx < kw)               return PK_IN_LOW;
        else if (idx < 4 * kw)      return PK_OD_LOW;
        else if (idx < 5 * kw)      return PK_SW_LOW;
        else if (idx < 5 * kw + fw) return PK_SW_LVL;
        else                        return PK_IN_LVL;
    endfunction

endpackage

// File: rtl/kr_sync.sv
`timescale 1ns/1ps
// Multi-bit synchroniser bank.
// Each bit is independent; assumes inputs are quasi-static levels, so no
// bus coherency across bits is needed.
module kr_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st_q [STAGES];

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
        end else begin
            st_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
        end
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/kr_pin_cell.sv
`timescale 1ns/1ps
// Per-pin decode: wake condition, direction, pull selection and output type.
// Assumes pin_i is already synchronised; dir_i is 1 for output.
// The KIND parameter selects which group rules apply.
module kr_pin_cell #(
    parameter kr_pkg::pin_kind_e KIND = kr_pkg::PK_IN_LOW
) (
    input  logic pin_i,
    input  logic dir_i,
    input  logic res_i,
    input  logic lvl_i,
    input  logic km_i,
    output logic cond_o,
    output logic oe_o,
    output logic pu_o,
    output logic pd_o,
    output logic od_o
);
    // Combinational decode of the pin's rules by kind.
    always_comb begin
        cond_o = 1'b0;
        oe_o   = 1'b0;
        pu_o   = 1'b0;
        pd_o   = 1'b0;
        od_o   = 1'b0;
        case (KIND)
            kr_pkg::PK_IN_LOW: begin
                pu_o   = 1'b1;
                cond_o = ~pin_i;
            end
            kr_pkg::PK_OD_LOW: begin
                oe_o   = dir_i;
                pu_o   = ~dir_i;
                od_o   = dir_i;
                cond_o = ~dir_i & ~pin_i;
            end
            kr_pkg::PK_SW_LOW: begin
                oe_o   = dir_i;
                pu_o   = ~dir_i & (km_i | res_i);
                od_o   = dir_i & km_i;
                cond_o = ~dir_i & ~pin_i;
            end
            kr_pkg::PK_SW_LVL: begin
                oe_o   = dir_i;
                pu_o   = ~dir_i & res_i & ~lvl_i;
                pd_o   = ~dir_i & res_i & lvl_i;
                od_o   = dir_i & km_i;
                cond_o = ~dir_i & (pin_i == lvl_i);
            end
            kr_pkg::PK_IN_LVL: begin
                pu_o   = res_i & ~lvl_i;
                pd_o   = res_i & lvl_i;
                cond_o = (pin_i == lvl_i);
            end
            default: begin
                cond_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/kr_int_filter.sv
`timescale 1ns/1ps
// Level stability filter for the interrupt path.
// A new level is accepted once the synchronised input has differed from the
// accepted level for FILT_CYC consecutive cycles; evt_o pulses for one cycle
// when the accepted level changes to the selected level. Assumes FILT_CYC >= 2.
module kr_int_filter #(
    parameter int FILT_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s_i,
    input  logic lvl_sel_i,
    output logic evt_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          acc_q;
    logic [CW-1:0] cnt_q;
    logic          evt_q;

    // Count consecutive disagreeing cycles and accept the level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (pin_s_i == acc_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYC - 1)) begin
                acc_q <= pin_s_i;
                cnt_q <= '0;
                evt_q <= (pin_s_i == lvl_sel_i);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign evt_o = evt_q;
endmodule

// File: rtl/kr_wake_core.sv
`timescale 1ns/1ps
// Wake pulse generator and sticky source mask.
// Assumes cond_i is a registered-domain vector. One pulse per standby episode;
// the episode ends when standby_i drops.
module kr_wake_core #(
    parameter int NPIN = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            standby_i,
    input  logic            clr_i,
    input  logic [NPIN-1:0] cond_i,
    output logic            wake_o,
    output logic [NPIN-1:0] src_o
);
    logic            wake_q;
    logic            fired_q;
    logic [NPIN-1:0] src_q;
    logic            pend;

    assign pend = standby_i & (|cond_i) & ~fired_q;

    // Issue the pulse, remember it for this episode, and collect sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q  <= 1'b0;
            fired_q <= 1'b0;
            src_q   <= '0;
        end else begin
            wake_q  <= pend;
            fired_q <= standby_i & (fired_q | (|cond_i));
            src_q   <= (clr_i ? '0 : src_q) | (pend ? cond_i : '0);
        end
    end

    assign wake_o = wake_q;
    assign src_o  = src_q;
endmodule

// File: rtl/kr_wake_ctrl.sv
`timescale 1ns/1ps
// Key-return standby wake controller (top).
// Flattens all groups into one pin mask, synchronises the pins, decodes each
// pin with its group rules, filters the interrupt path and drives the wake core.
// Assumes configuration inputs come from registers in the clock domain.
module kr_wake_ctrl #(
    parameter int KW       = 4,
    parameter int FW       = 3,
    parameter int FILT_CYC = 40,
    parameter int SYNC_STG = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  standby_i,
    input  logic                  km_mode_i,
    input  logic [KW-1:0]         ka_pin_i,
    input  logic [KW-1:0]         kb_pin_i,
    input  logic [KW-1:0]         kc_pin_i,
    input  logic [KW-1:0]         kd_pin_i,
    input  logic [KW-1:0]         ke_pin_i,
    input  logic [FW-1:0]         kf_pin_i,
    input  logic                  kg_pin_i,
    input  logic [KW-1:0]         kb_dir_i,
    input  logic                  kc_dir_i,
    input  logic                  kd_dir_i,
    input  logic [KW-1:0]         ke_dir_i,
    input  logic [FW-1:0]         kf_dir_i,
    input  logic [KW-1:0]         ke_res_i,
    input  logic [FW-1:0]         kf_res_i,
    input  logic [FW-1:0]         kf_lvl_i,
    input  logic                  kg_res_i,
    input  logic                  kg_lvl_i,
    input  logic                  kg_int_sel_i,
    input  logic                  int_en_i,
    input  logic                  src_clr_i,
    output logic                  wake_o,
    output logic [5*KW+FW:0]      src_o,
    output logic [5*KW+FW:0]      oe_o,
    output logic [5*KW+FW:0]      pu_o,
    output logic [5*KW+FW:0]      pd_o,
    output logic [5*KW+FW:0]      od_o
);
    localparam int NPIN = 5 * KW + FW + 1;
    localparam int KG   = NPIN - 1;

    logic [NPIN-1:0] pin_raw, pin_s;
    logic [NPIN-1:0] dir_v, res_v, lvl_v;
    logic [NPIN-1:0] cell_cond, cond_v;
    logic            int_evt;

    // Flatten group vectors into the shared pin mask layout.
    assign pin_raw = {kg_pin_i, kf_pin_i, ke_pin_i, kd_pin_i, kc_pin_i, kb_pin_i, ka_pin_i};
    assign dir_v   = {1'b0, kf_dir_i, ke_dir_i, {KW{kd_dir_i}}, {KW{kc_dir_i}}, kb_dir_i, {KW{1'b0}}};
    assign res_v   = {kg_res_i, kf_res_i, ke_res_i, {(3*KW){1'b0}}, {KW{1'b0}}};
    assign lvl_v   = {kg_lvl_i, kf_lvl_i, {(5*KW){1'b0}}};

    kr_sync #(.W(NPIN), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_raw),
        .q_o   (pin_s)
    );

    // One decode cell per pin, its rules picked from the index.
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        kr_pin_cell #(.KIND(kr_pkg::kind_of(g, KW, FW))) u_cell (
            .pin_i  (pin_s[g]),
            .dir_i  (dir_v[g]),
            .res_i  (res_v[g]),
            .lvl_i  (lvl_v[g]),
            .km_i   (km_mode_i),
            .cond_o (cell_cond[g]),
            .oe_o   (oe_o[g]),
            .pu_o   (pu_o[g]),
            .pd_o   (pd_o[g]),
            .od_o   (od_o[g])
        );
    end

    kr_int_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_s_i   (pin_s[KG]),
        .lvl_sel_i (kg_lvl_i),
        .evt_o     (int_evt)
    );

    // Single pin: interrupt path replaces the key-return condition when selected.
    always_comb begin
        cond_v     = cell_cond;
        cond_v[KG] = kg_int_sel_i ? (int_en_i & int_evt) : cell_cond[KG];
    end

    kr_wake_core #(.NPIN(NPIN)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (standby_i),
        .clr_i     (src_clr_i),
        .cond_i    (cond_v),
        .wake_o    (wake_o),
        .src_o     (src_o)
    );
endmodule

// File: rtl/kr_wake_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for kr_wake_ctrl, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module kr_wake_ctrl_chk #(
    parameter int NPIN = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            standby_i,
    input logic            src_clr_i,
    input logic            wake_o,
    input logic [NPIN-1:0] src_o,
    input logic [NPIN-1:0] oe_o,
    input logic [NPIN-1:0] pu_o,
    input logic [NPIN-1:0] pd_o,
    input logic [NPIN-1:0] od_o
);
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    p_wake_in_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(standby_i));

    p_src_on_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (src_o != '0));

    p_src_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(src_clr_i) |-> ((src_o & $past(src_o)) == $past(src_o)));

    p_pull_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_o & pd_o) == '0);

    p_no_pull_on_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o & (pu_o | pd_o)) == '0);

    p_od_needs_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (od_o & ~oe_o) == '0);
endmodule

bind kr_wake_ctrl kr_wake_ctrl_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_i),
    .src_clr_i (src_clr_i),
    .wake_o    (wake_o),
    .src_o     (src_o),
    .oe_o      (oe_o),
    .pu_o      (pu_o),
    .pd_o      (pd_o),
    .od_o      (od_o)
);

// File: tb/tb_kr_wake_ctrl.sv
`timescale 1ns/1ps
// Bench for kr_wake_ctrl: random configurations plus directed corner cases.
module tb_kr_wake_ctrl;
    localparam int KW = 4;
    localparam int FW = 3;
    localparam int FC = 6;
    localparam int NP = 5 * KW + FW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby, km, kc_dir, kd_dir, kg, kg_res, kg_lvl, int_sel, int_en, clr;
    logic [KW-1:0] ka, kb, kc, kd, ke, kb_dir, ke_dir, ke_res;
    logic [FW-1:0] kf, kf_dir, kf_res, kf_lvl;
    logic wake;
    logic [NP-1:0] src, oe, pu, pd, od;
    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    kr_wake_ctrl #(.KW(KW), .FW(FW), .FILT_CYC(FC)) dut (
        .clk(clk), .rst_n(rst_n), .standby_i(standby), .km_mode_i(km),
        .ka_pin_i(ka), .kb_pin_i(kb), .kc_pin_i(kc), .kd_pin_i(kd), .ke_pin_i(ke),
        .kf_pin_i(kf), .kg_pin_i(kg), .kb_dir_i(kb_dir), .kc_dir_i(kc_dir),
        .kd_dir_i(kd_dir), .ke_dir_i(ke_dir), .kf_dir_i(kf_dir), .ke_res_i(ke_res),
        .kf_res_i(kf_res), .kf_lvl_i(kf_lvl), .kg_res_i(kg_res), .kg_lvl_i(kg_lvl),
        .kg_int_sel_i(int_sel), .int_en_i(int_en), .src_clr_i(clr),
        .wake_o(wake), .src_o(src), .oe_o(oe), .pu_o(pu), .pd_o(pd), .od_o(od)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] exp_cond();
        logic [NP-1:0] m;
        for (int i = 0; i < KW; i++) begin
            m[i]        = ~ka[i];
            m[KW+i]     = ~kb_dir[i] & ~kb[i];
            m[2*KW+i]   = ~kc_dir & ~kc[i];
            m[3*KW+i]   = ~kd_dir & ~kd[i];
            m[4*KW+i]   = ~ke_dir[i] & ~ke[i];
        end
        for (int j = 0; j < FW; j++) m[5*KW+j] = ~kf_dir[j] & (kf[j] == kf_lvl[j]);
        m[NP-1] = ~int_sel & (kg == kg_lvl);
        return m;
    endfunction

    function automatic logic [NP-1:0] exp_oe();
        return {1'b0, kf_dir, ke_dir, {KW{kd_dir}}, {KW{kc_dir}}, kb_dir, {KW{1'b0}}};
    endfunction

    function automatic logic [NP-1:0] exp_pu();
        logic [NP-1:0] m = '0;
        for (int i = 0; i < KW; i++) begin
            m[i]      = 1'b1;
            m[KW+i]   = ~kb_dir[i];
            m[2*KW+i] = ~kc_dir;
            m[3*KW+i] = ~kd_dir;
            m[4*KW+i] = ~ke_dir[i] & (km | ke_res[i]);
        end
        for (int j = 0; j < FW; j++) m[5*KW+j] = ~kf_dir[j] & kf_res[j] & ~kf_lvl[j];
        m[NP-1] = kg_res & ~kg_lvl;
        return m;
    endfunction

    function automatic logic [NP-1:0] exp_pd();
        logic [NP-1:0] m = '0;
        for (int j = 0; j < FW; j++) m[5*KW+j] = ~kf_dir[j] & kf_res[j] & kf_lvl[j];
        m[NP-1] = kg_res & kg_lvl;
        return m;
    endfunction

    function automatic logic [NP-1:0] exp_od();
        logic [NP-1:0] m = '0;
        for (int i = 0; i < KW; i++) begin
            m[KW+i]   = kb_dir[i];
            m[2*KW+i] = kc_dir;
            m[3*KW+i] = kd_dir;
            m[4*KW+i] = ke_dir[i] & km;
        end
        for (int j = 0; j < FW; j++) m[5*KW+j] = kf_dir[j] & km;
        return m;
    endfunction

    task automatic idle();
        ka = '1; kb = '1; kc = '1; kd = '1; ke = '1; kf = '1; kg = 1'b1;
        kb_dir = '0; kc_dir = 1'b0; kd_dir = 1'b0; ke_dir = '0; kf_dir = '0;
        ke_res = '0; kf_res = '0; kf_lvl = '0; kg_res = 1'b0; kg_lvl = 1'b0;
        int_sel = 1'b0; int_en = 1'b0; km = 1'b0;
    endtask

    task automatic randomize_cfg();
        {ka, kb, kc, kd} = $urandom;
        {ke, kf, kg} = 8'($urandom);
        {kb_dir, ke_dir, kf_dir, kc_dir, kd_dir} = 13'($urandom);
        {ke_res, kf_res, kf_lvl, kg_res, kg_lvl, km} = 13'($urandom);
        int_sel = 1'b0; int_en = 1'b0;
    endtask

    task automatic count_wakes(input int n, output int cnt);
        cnt = 0;
        repeat (n) begin
            @(negedge clk);
            if (wake) cnt++;
        end
    endtask

    // Settle pins with standby low, clear, then one standby episode.
    task automatic run_case(input logic [NP-1:0] exp, input string req);
        int cnt;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        count_wakes(3, cnt);
        chk(cnt == 0, "R10 no wake without standby", cnt, 0);
        standby = 1'b1;
        count_wakes(6, cnt);
        chk(cnt == ((exp != '0) ? 1 : 0), req, cnt, (exp != '0) ? 1 : 0);
        chk(src == exp, req, src, exp);
        standby = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        logic [NP-1:0] e;
        void'($urandom(32'd1357));
        idle(); standby = 1'b0; clr = 1'b0;
        repeat (5) @(negedge clk);
        chk(wake == 1'b0, "R12 wake after reset", wake, 0);
        chk(src == '0, "R12 src after reset", src, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R5 / R6: pad control decode under random configurations.
        for (int it = 0; it < 40; it++) begin
            @(negedge clk);
            randomize_cfg();
            #1;
            chk(oe == exp_oe(), "R6 direction", oe, exp_oe());
            chk(od == exp_od(), "R6 output type", od, exp_od());
            chk(pu == exp_pu(), "R5 pull-up", pu, exp_pu());
            chk(pd == exp_pd(), "R5 pull-down", pd, exp_pd());
        end

        // R9 / R11: random wake episodes, pulse in first standby cycle only.
        for (int it = 0; it < 60; it++) begin
            @(negedge clk);
            randomize_cfg();
            clr = 1'b1;
            @(negedge clk); clr = 1'b0;
            repeat (3) @(negedge clk);
            e = exp_cond();
            standby = 1'b1;
            @(negedge clk);
            chk(wake == (e != '0), "R9 random wake", wake, (e != '0));
            chk(src == e, "R11 random source mask", src, e);
            count_wakes(3, cnt);
            chk(cnt == 0, "R9 no repeat", cnt, 0);
            standby = 1'b0;
        end

        // R1 and R9 timing: input-only line, wake three edges after change.
        @(negedge clk); idle(); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        repeat (3) @(negedge clk);
        standby = 1'b1;
        repeat (2) @(negedge clk);
        ka[2] = 1'b0;
        @(negedge clk); chk(wake == 1'b0, "R9 edge 1", wake, 0);
        @(negedge clk); chk(wake == 1'b0, "R9 edge 2", wake, 0);
        @(negedge clk); chk(wake == 1'b1, "R1 R9 edge 3", wake, 1);
        chk(src == NP'(1) << 2, "R1 source", src, NP'(1) << 2);
        standby = 1'b0;

        // R10: conditions present without standby leave mask untouched.
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        ka = '0;
        count_wakes(8, cnt);
        chk(cnt == 0, "R10 wake ignored", cnt, 0);
        chk(src == '0, "R10 mask untouched", src, 0);

        // R2: whole-unit group as outputs cannot wake, then released.
        idle(); kc = '0; kc_dir = 1'b1;
        run_case('0, "R2 group output ignored");
        standby = 1'b1;
        repeat (2) @(negedge clk);
        kc_dir = 1'b0;
        @(negedge clk);
        chk(wake == 1'b1, "R2 group input wakes", wake, 1);
        chk(src == NP'(32'h0F00), "R2 group sources", src, 32'h0F00);
        standby = 1'b0;
        idle(); kd = 4'b1101;
        run_case(NP'(32'h2000), "R2 second group bit");

        // R3: bit-switched groups; output bits ignored.
        idle(); kb = 4'b1101; kb_dir = 4'b0010;
        run_case('0, "R3 output bit ignored");
        idle(); ke = 4'b0110; ke_dir = 4'b0001;
        run_case(NP'(32'h80000), "R3 input bit wakes");

        // R4: selectable levels.
        idle(); kf_lvl = 3'b010; kf = 3'b111;
        run_case(NP'(32'h200000), "R4 high level bit");
        idle(); kf_lvl = 3'b000; kf = 3'b011; kf_dir = 3'b100;
        run_case('0, "R4 low level on output bit ignored");
        idle(); kg_lvl = 1'b1; kg = 1'b1;
        run_case(NP'(32'h800000), "R4 single pin high level");

        // R11: clear, and clear coinciding with a new wake.
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(src == '0, "R11 clear", src, 0);
        idle(); ka[0] = 1'b0;
        run_case(NP'(1), "R11 first source");
        idle(); kb[3] = 1'b0;
        repeat (3) @(negedge clk);
        standby = 1'b1; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(src == NP'(32'h80), "R11 clear with wake", src, 32'h80);
        standby = 1'b0;

        // R7 / R8: interrupt path through the filter.
        @(negedge clk); idle();
        int_sel = 1'b1; kg_lvl = 1'b1; kg = 1'b0;
        repeat (FC + 8) @(negedge clk);
        clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        standby = 1'b1;
        kg = 1'b1;
        count_wakes(FC + 8, cnt);
        chk(cnt == 0, "R7 interrupt disabled", cnt, 0);
        kg = 1'b0;
        count_wakes(FC + 8, cnt);
        chk(cnt == 0, "R7 key-return ignored", cnt, 0);
        int_en = 1'b1;
        kg = 1'b1;
        repeat (FC - 2) @(negedge clk);
        kg = 1'b0;
        count_wakes(FC + 8, cnt);
        chk(cnt == 0, "R8 short glitch rejected", cnt, 0);
        kg = 1'b1;
        cnt = 0;
        for (int k = 1; k <= FC + 6; k++) begin
            @(negedge clk);
            if (wake && cnt == 0) cnt = k;
        end
        chk(cnt == FC + 3, "R8 acceptance cycle", cnt, FC + 3);
        chk(src == NP'(1) << (NP - 1), "R7 interrupt source", src, NP'(1) << (NP - 1));
        standby = 1'b0;

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule